// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block holds the digital control for a successive-approximation converter. While enabled, it divides the system clock into an ADC clock, which it issues as a one-cycle enable pulse. It times each conversion in ADC clock periods and fires a sample-and-hold strobe. It then runs a 10-bit binary search, presenting each trial code to the DAC and keeping or dropping each bit according to a comparator decision. The result is written into a low and a high byte register, in either right-adjusted or left-adjusted form, and a completion flag is set.

Most conversions take 13 ADC clock periods. The first conversion after enabling takes 25, and so does the first conversion after the reference select changes or a differential channel is picked. Reading the low byte freezes both result bytes until the high byte is read, so that the two bytes always come from the same conversion. A conversion that finishes while the bytes are frozen is discarded, but the completion flag is still set.

Conversions run either one per start request or back to back. A differential channel can only start on every other ADC clock edge, counted from enable.

Top module: `sar_seq`

## Requirements
- R1: With `en_i` high, `tick_o` is a one-cycle pulse every 2^max(`ps_i`,1) clock cycles. With `en_i` low, the prescaler is held cleared and no tick occurs.
- R2: The first conversion after `en_i` rises is extended. It completes on the 25th tick after its start tick, and `sh_o` pulses at the midpoint of the period that follows the 13th tick.
- R3: A conversion starts on the first tick after the clock edge that captured `start_i`. A normal conversion completes on the 13th tick after its start tick, and `sh_o` pulses once, at the midpoint of the period after the 1st tick.
- R4: A change of `ref_i`, or a change of `chan_i` to a value with bit 2 set (differential), makes the next conversion extended.
- R5: The result is the binary search driven by `cmp_i`: a 1 keeps the trial bit and a 0 clears it. With `ladj_i`=0, `data_lo_o` = result[7:0] and `data_hi_o` = {6'b0, result[9:8]}. With `ladj_i`=1, `data_hi_o` = result[9:2] and `data_lo_o` = {result[1:0], 6'b0}.
- R6: A `rd_lo_i` pulse freezes both data bytes until a `rd_hi_i` pulse. A conversion that completes while the bytes are frozen leaves them unchanged but still sets `flag_o`.
- R7: In single mode (`free_i`=0), `busy_o` goes high on the edge after `start_i` and falls on the completion edge.
- R8: In free-running mode (`free_i`=1), `busy_o` stays high, and the completion tick is also the start tick of the next conversion, which is a normal one.
- R9: With `chan_i[2]`=1, a start is allowed only on the odd-numbered ticks counted from enable (the 1st, 3rd, 5th and so on).
- R10: `flag_o` is set by every completion and stays set until `flag_clr_i` is high at a clock edge. If a completion and a clear fall on the same edge, the set wins.
- R11: After reset, `busy_o`, `flag_o`, `tick_o`, `sh_o` and both data bytes are 0.
- R12: `mux_o` holds the channel captured at the start of the conversion and ignores changes of `chan_i` during that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | converter enable; low clears prescaler and sequencing |
| start_i | input | 1 | pulse that sets the start bit |
| free_i | input | 1 | 1 = free-running, 0 = single conversion |
| ps_i | input | 3 | prescaler select, division 2^max(ps,1) |
| ref_i | input | 2 | reference select |
| chan_i | input | 3 | channel select; bit 2 marks a differential channel |
| ladj_i | input | 1 | left-adjusted result format |
| cmp_i | input | 1 | comparator decision: 1 means input at or above `dac_o` |
| rd_lo_i | input | 1 | low byte read strobe |
| rd_hi_i | input | 1 | high byte read strobe |
| flag_clr_i | input | 1 | write-one-to-clear for the completion flag |
| tick_o | output | 1 | ADC clock enable pulse |
| sh_o | output | 1 | sample-and-hold strobe |
| busy_o | output | 1 | start bit |
| dac_o | output | 10 | current trial code for the DAC |
| mux_o | output | 3 | channel captured at conversion start |
| data_lo_o | output | 8 | result low byte |
| data_hi_o | output | 8 | result high byte |
| flag_o | output | 1 | completion flag |

## Verification
A wrong conversion counter or a wrong extended/normal choice moves the completion by whole ADC periods. That shows up at the first flag after the fault as a tick count that differs from the expected 13 or 25, or from 26 or 27 for a differential channel that has to wait for its slot. A broken binary search appears as a wrong data byte on that same completion. A lost or stuck lock shows up at the next completion after a read, because the bytes change when they should hold or hold when they should change. The strobe position is recorded against the tick count, so a sample strobe misplaced by even one period is reported at the end of that conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W = 10;
  localparam int CYC_W = 5;
  localparam logic [CYC_W-1:0] LEN_NORM = 5'd13;
  localparam logic [CYC_W-1:0] LEN_EXT  = 5'd25;
  localparam logic [CYC_W-1:0] SMP_NORM = 5'd1;
  localparam logic [CYC_W-1:0] SMP_EXT  = 5'd13;

  function automatic logic [15:0] pack_result(input logic [RES_W-1:0] r, input logic left);
    pack_result = left ? {r, {(16-RES_W){1'b0}}} : {{(16-RES_W){1'b0}}, r};
  endfunction
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o,
  output logic            half_o
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim, mid;
  logic [PS_W-1:0]  sel;

  always_comb begin
    sel    = (ps_i == '0) ? PS_W'(1) : ps_i;
    lim    = {CNT_W{1'b1}} >> (PS_W'(CNT_W) - sel);
    mid    = lim >> 1;
    tick_o = en_i & (cnt_q >= lim);
    half_o = en_i & (cnt_q == mid);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl import sar_pkg::*; #(
  parameter int CH_W  = 3,
  parameter int REF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             half_i,
  input  logic             start_i,
  input  logic             free_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             sh_o,
  output logic             done_o,
  output logic [RES_W-1:0] sar_o,
  output logic [CH_W-1:0]  mux_o
);
  logic             act_q, start_q, par_q, ext_pend_q, ext_q;
  logic [CYC_W-1:0] cyc_q, idx, len, smp;
  logic [REF_W-1:0] ref_q;
  logic [CH_W-1:0]  chan_q, mux_q;
  logic [RES_W-1:0] sar_q, trial;
  logic [3:0]       bsel;
  logic             fin, diff_ok, begin_new, dec, chg;

  always_comb begin
    idx       = cyc_q + CYC_W'(1);
    len       = ext_q ? LEN_EXT : LEN_NORM;
    smp       = ext_q ? SMP_EXT : SMP_NORM;
    fin       = act_q & tick_i & (idx == len);
    diff_ok   = ~chan_i[CH_W-1] | ~par_q;
    begin_new = tick_i & start_q & (act_q ? (fin & free_i) : diff_ok);
    dec       = act_q & tick_i & ~fin & (idx >= smp + CYC_W'(2)) & (idx <= smp + CYC_W'(11));
    bsel      = 4'(smp + CYC_W'(11) - idx);
    trial     = RES_W'(1) << bsel;
    sh_o      = act_q & half_i & (cyc_q == smp);
    chg       = (ref_i != ref_q) | ((chan_i != chan_q) & chan_i[CH_W-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; start_q <= 1'b0; par_q <= 1'b0; ext_pend_q <= 1'b1; ext_q <= 1'b0;
      cyc_q <= '0; ref_q <= '0; chan_q <= '0; mux_q <= '0; sar_q <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0; start_q <= 1'b0; par_q <= 1'b0; ext_pend_q <= 1'b1;
      cyc_q <= '0; sar_q <= '0; ref_q <= ref_i; chan_q <= chan_i;
    end else begin
      ref_q  <= ref_i;
      chan_q <= chan_i;
      if (tick_i) par_q <= ~par_q;
      if (start_i)             start_q <= 1'b1;
      else if (fin && !free_i) start_q <= 1'b0;
      if (chg)            ext_pend_q <= 1'b1;
      else if (begin_new) ext_pend_q <= 1'b0;
      if (begin_new) begin
        act_q <= 1'b1;
        cyc_q <= '0;
        ext_q <= ext_pend_q;
        mux_q <= chan_i;
        sar_q <= '0;
      end else begin
        if (fin)                 act_q <= 1'b0;
        else if (act_q && tick_i) cyc_q <= idx;
        if (sh_o)     sar_q <= RES_W'(1) << (RES_W - 1);
        else if (dec) sar_q <= (cmp_i ? sar_q : (sar_q & ~trial)) | (trial >> 1);
      end
    end
  end

  assign busy_o = start_q;
  assign done_o = fin;
  assign sar_o  = sar_q;
  assign mux_o  = mux_q;
endmodule

// File: rtl/sar_result.sv
module sar_result import sar_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             ladj_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic             flag_clr_i,
  output logic [7:0]       data_lo_o,
  output logic [7:0]       data_hi_o,
  output logic             flag_o
);
  logic        lock_q, flag_q;
  logic [15:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      flag_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (rd_hi_i)      lock_q <= 1'b0;
      else if (rd_lo_i) lock_q <= 1'b1;
      if (done_i && !lock_q) data_q <= pack_result(res_i, ladj_i);
      if (done_i)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign data_lo_o = data_q[7:0];
  assign data_hi_o = data_q[15:8];
  assign flag_o    = flag_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq import sar_pkg::*; #(
  parameter int PS_W  = 3,
  parameter int CH_W  = 3,
  parameter int REF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             free_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             ladj_i,
  input  logic             cmp_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic             flag_clr_i,
  output logic             tick_o,
  output logic             sh_o,
  output logic             busy_o,
  output logic [RES_W-1:0] dac_o,
  output logic [CH_W-1:0]  mux_o,
  output logic [7:0]       data_lo_o,
  output logic [7:0]       data_hi_o,
  output logic             flag_o
);
  logic tick, half, done;
  logic [RES_W-1:0] sar;

  sar_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ps_i(ps_i),
    .tick_o(tick), .half_o(half)
  );

  sar_ctrl #(.CH_W(CH_W), .REF_W(REF_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .half_i(half),
    .start_i(start_i), .free_i(free_i), .ref_i(ref_i), .chan_i(chan_i), .cmp_i(cmp_i),
    .busy_o(busy_o), .sh_o(sh_o), .done_o(done), .sar_o(sar), .mux_o(mux_o)
  );

  sar_result u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .res_i(sar), .ladj_i(ladj_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .flag_clr_i(flag_clr_i),
    .data_lo_o(data_lo_o), .data_hi_o(data_hi_o), .flag_o(flag_o)
  );

  assign tick_o = tick;
  assign dac_o  = sar;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       rd_lo_i,
  input logic       rd_hi_i,
  input logic       flag_clr_i,
  input logic       tick_o,
  input logic       sh_o,
  input logic       busy_o,
  input logic       flag_o,
  input logic [7:0] data_lo_o,
  input logic [7:0] data_hi_o
);
  logic lk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lk_q <= 1'b0;
    else if (rd_hi_i) lk_q <= 1'b0;
    else if (rd_lo_i) lk_q <= 1'b1;
  end

  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r1_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
  a_r3_sh_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |=> !sh_o);
  a_r3_sh_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |-> (busy_o && !tick_o));
  a_r6_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_q |=> ($stable(data_lo_o) && $stable(data_hi_o)));
  a_r7_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!$past(en_i) || $past(tick_o)));
  a_r10_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  a_r10_flag_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(tick_o));
endmodule

bind sar_seq sar_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
  .flag_clr_i(flag_clr_i), .tick_o(tick_o), .sh_o(sh_o), .busy_o(busy_o),
  .flag_o(flag_o), .data_lo_o(data_lo_o), .data_hi_o(data_hi_o)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int CLK_P = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, start_i = 0, free_i = 0, ladj_i = 0, rd_lo_i = 0, rd_hi_i = 0, flag_clr_i = 0;
  logic [2:0] ps_i = 0, chan_i = 0;
  logic [1:0] ref_i = 0;
  logic [9:0] vin = 0;
  logic cmp_i, tick_o, sh_o, busy_o, flag_o;
  logic [9:0] dac_o;
  logic [2:0] mux_o;
  logic [7:0] data_lo_o, data_hi_o;

  always #(CLK_P/2) clk_i = ~clk_i;
  assign cmp_i = (vin >= dac_o);

  sar_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .start_i(start_i), .free_i(free_i),
    .ps_i(ps_i), .ref_i(ref_i), .chan_i(chan_i), .ladj_i(ladj_i), .cmp_i(cmp_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .flag_clr_i(flag_clr_i), .tick_o(tick_o),
    .sh_o(sh_o), .busy_o(busy_o), .dac_o(dac_o), .mux_o(mux_o), .data_lo_o(data_lo_o),
    .data_hi_o(data_hi_o), .flag_o(flag_o)
  );

  // scoreboard, written by the driver, read by the monitor
  logic [15:0] exp_dat [16];
  int          exp_tk  [16];
  int          exp_sh  [16];
  bit          exp_busy[16];
  string       exp_tag [16];
  int wr_idx = 0;
  int chk_d = 0, bad_d = 0;

  // monitor-owned
  int tabs = 0, sh_abs = -1, rd_idx = 0, hold = 0, chk_m = 0, bad_m = 0;

  always @(negedge clk_i) begin
    if (tick_o) tabs++;
    if (sh_o) sh_abs = tabs;
    case (hold)
      0: if (flag_o) begin
        if (rd_idx >= wr_idx) begin
          chk_m++; bad_m++;
          $display("FAIL R10 unexpected completion act=1 exp=0");
        end else begin
          chk_m++;
          if ({data_hi_o, data_lo_o} !== exp_dat[rd_idx]) begin
            bad_m++;
            $display("FAIL %s data act=%h exp=%h", exp_tag[rd_idx], {data_hi_o, data_lo_o}, exp_dat[rd_idx]);
          end
          chk_m++;
          if (tabs != exp_tk[rd_idx]) begin
            bad_m++;
            $display("FAIL %s completion tick act=%0d exp=%0d", exp_tag[rd_idx], tabs, exp_tk[rd_idx]);
          end
          chk_m++;
          if (sh_abs != exp_sh[rd_idx]) begin
            bad_m++;
            $display("FAIL %s sample tick act=%0d exp=%0d", exp_tag[rd_idx], sh_abs, exp_sh[rd_idx]);
          end
          chk_m++;
          if (busy_o !== exp_busy[rd_idx]) begin
            bad_m++;
            $display("FAIL %s R7 R8 busy act=%b exp=%b", exp_tag[rd_idx], busy_o, exp_busy[rd_idx]);
          end
          rd_idx++;
        end
        hold = 1;
      end
      1, 2: hold++;
      3: begin
        chk_m++;
        if (flag_o !== 1'b1) begin bad_m++; $display("FAIL R10 flag held act=%b exp=1", flag_o); end
        flag_clr_i = 1'b1;
        hold = 4;
      end
      default: begin
        flag_clr_i = 1'b0;
        chk_m++;
        if (flag_o !== 1'b0) begin bad_m++; $display("FAIL R10 flag cleared act=%b exp=0", flag_o); end
        hold = 0;
      end
    endcase
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk_d++;
    if (!ok) begin
      bad_d++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [9:0] v, input logic l);
    fmt = l ? {v, 6'b0} : {6'b0, v};
  endfunction

  int en_base = 0;
  bit ext_m = 1, lock_m = 0;
  logic [15:0] cur = 0;
  int mid_chan = -1;

  task automatic tick_period(input int exp, input string tag);
    int c = 0;
    do @(negedge clk_i); while (!tick_o);
    do begin @(negedge clk_i); c++; end while (!tick_o);
    if (exp > 0) check(c == exp, tag, c, exp);
  endtask

  task automatic request(output int base, output int w);
    int n;
    do @(negedge clk_i); while (!tick_o);
    @(negedge clk_i); #1;
    n = tabs - en_base;
    w = (chan_i[2] && ((n + 1) % 2 == 0)) ? 2 : 1;
    base = tabs;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic conv(input logic [9:0] v, input string tag);
    int base, w, len, smp;
    vin = v;
    request(base, w);
    len = ext_m ? 25 : 13;
    smp = ext_m ? 13 : 1;
    if (!lock_m) cur = fmt(v, ladj_i);
    exp_dat[wr_idx] = cur; exp_tk[wr_idx] = base + w + len; exp_sh[wr_idx] = base + w + smp;
    exp_busy[wr_idx] = 1'b0; exp_tag[wr_idx] = tag;
    wr_idx++;
    ext_m = 0;
    pulse_start();
    check(busy_o === 1'b1, "R7 busy after start", busy_o, 1);
    if (mid_chan >= 0) begin
      repeat (4) @(negedge clk_i);
      #1 chan_i = 3'(mid_chan);
    end
    wait (rd_idx == wr_idx && hold == 0);
  endtask

  initial begin
    int c, base, w;
    repeat (3) @(negedge clk_i);
    check({busy_o, flag_o, tick_o, sh_o} === 4'b0, "R11 control in reset", {busy_o, flag_o, tick_o, sh_o}, 0);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check({data_hi_o, data_lo_o} === 16'h0, "R11 data after reset", {data_hi_o, data_lo_o}, 0);

    // R1: prescaler
    #1 en_i = 1'b1; en_base = tabs; ext_m = 1;
    tick_period(2, "R1 period ps0");
    ps_i = 3'd3;
    tick_period(0, "R1 settle");
    tick_period(8, "R1 period ps3");
    ps_i = 3'd1;
    tick_period(0, "R1 settle");
    tick_period(2, "R1 period ps1");
    @(negedge clk_i); #1 en_i = 1'b0;
    c = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); if (tick_o) c++; end
    check(c == 0, "R1 no tick while disabled", c, 0);
    #1 en_i = 1'b1; en_base = tabs; ext_m = 1;

    conv(10'h2A5, "R2 R5 extended first");
    conv(10'h3FF, "R3 R5 normal full scale");
    conv(10'h000, "R3 R5 normal zero");
    ladj_i = 1'b1;
    conv(10'h155, "R5 left adjust");
    ladj_i = 1'b0;
    ref_i = 2'd1; ext_m = 1;
    conv(10'h0C3, "R4 reference change");

    // R6: lock
    @(negedge clk_i); #1 rd_lo_i = 1'b1;
    @(negedge clk_i); #1 rd_lo_i = 1'b0; lock_m = 1;
    conv(10'h123, "R6 result dropped while locked");
    @(negedge clk_i); #1 rd_hi_i = 1'b1;
    @(negedge clk_i); #1 rd_hi_i = 1'b0; lock_m = 0;
    conv(10'h0F0, "R6 update after unlock");

    // R8: free running, two conversions
    vin = 10'h200; free_i = 1'b1;
    request(base, w);
    cur = fmt(10'h200, 1'b0);
    exp_dat[wr_idx] = cur; exp_tk[wr_idx] = base + 1 + 13; exp_sh[wr_idx] = base + 2;
    exp_busy[wr_idx] = 1'b1; exp_tag[wr_idx] = "R8 first"; wr_idx++;
    exp_dat[wr_idx] = cur; exp_tk[wr_idx] = base + 1 + 26; exp_sh[wr_idx] = base + 1 + 14;
    exp_busy[wr_idx] = 1'b0; exp_tag[wr_idx] = "R8 back to back"; wr_idx++;
    pulse_start();
    wait (rd_idx == wr_idx - 1);
    free_i = 1'b0;
    wait (rd_idx == wr_idx && hold == 0);
    repeat (3) @(negedge clk_i);
    check(busy_o === 1'b0, "R7 start bit clear after stop", busy_o, 0);

    // R9, R4, R12: differential channel
    @(negedge clk_i); #1 chan_i = 3'd4; ext_m = 1;
    conv(10'h301, "R9 R4 differential extended");
    check(mux_o === 3'd4, "R12 channel captured", mux_o, 4);
    mid_chan = 2;
    conv(10'h07F, "R9 R12 differential normal");
    mid_chan = -1;
    check(mux_o === 3'd4, "R12 channel held during conversion", mux_o, 4);

    repeat (4) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", chk_d + chk_m, bad_d + bad_m);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    $display("FAIL watchdog expired (all requirements) act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", chk_d + chk_m + 1, bad_d + bad_m + 1);
    $finish;
  end
endmodule